// File: doc/BRIEF.md
# Encoder Velocity Capture Unit

This block measures how fast a rotary encoder turns. It counts the position pulses that an upstream quadrature decoder produces, over a time window of fixed length. Each pulse first passes through a power-of-two predivider. The divided pulses then go into a signed accumulator. A forward pulse adds one and a reverse pulse subtracts one. A down-counting timer, reloaded from a programmable value, sets the window. When the timer reaches zero, the accumulator total is copied into a speed register and a new window begins. The block also raises a one-cycle strobe that can serve as an interrupt source.

Capture has its own enable, but it only runs while the encoder enable is also set. A stall input freezes the timer, the predivider and the accumulator while a halt request is present.

Top module: `enc_vel_capture`

## Requirements
- R1: While `rst` is high, `timer_o`, `accum_o`, `speed_o` and `win_end_o` are all zero.
- R2: While capture is not running (`enc_en_i` or `vel_en_i` low), every clock loads `timer_o` with `load_val_i`, clears `accum_o`, keeps `win_end_o` low and leaves `speed_o` unchanged.
- R3: With predivider code k on `prediv_sel_i` (0..7), the accumulator moves by one for every 2^k accepted pulses. The predivider phase is cleared whenever capture is not running.
- R4: A divided pulse with `dir_i`=0 (forward) increments the accumulator. With `dir_i`=1 (reverse) it decrements the accumulator, in two's complement.
- R5: While running, `timer_o` decrements by one per clock. In a cycle where it is zero, it reloads `load_val_i` on the next clock, so each window spans `load_val_i`+1 clocks.
- R6: In a cycle where the running timer is zero, `speed_o` takes the accumulator value and the accumulator restarts. A divided pulse in that same cycle counts as the first step of the new window.
- R7: `win_end_o` is high for exactly the one clock after each zero-timer cycle, the same clock in which `speed_o` shows the new result.
- R8: When `stall_en_i` and `halt_i` are both high, the timer, the accumulator and the predivider hold and no strobe is produced. `halt_i` alone has no effect.
- R9: `vel_en_i`=1 with `enc_en_i`=0 behaves as capture disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en_i | input | 1 | Encoder enable |
| vel_en_i | input | 1 | Velocity capture enable |
| stall_en_i | input | 1 | Allows halt to freeze the unit |
| halt_i | input | 1 | Halt request |
| pulse_i | input | 1 | One-cycle decoded position pulse |
| dir_i | input | 1 | Direction of the pulse, 0 forward, 1 reverse |
| prediv_sel_i | input | 3 | Predivider code, divide by 2^code |
| load_val_i | input | 32 | Timer reload value |
| timer_o | output | 32 | Running timer value |
| accum_o | output | 32 | Signed running pulse accumulator |
| speed_o | output | 32 | Signed count latched at the last window end |
| win_end_o | output | 1 | One-cycle window-end strobe |

## Verification
The assertions assume that `pulse_i` is a one-cycle-qualified pulse that is sampled every clock. They also assume that `dir_i` is valid whenever a pulse is present. They assume that `load_val_i` may change at any time and only takes effect on a reload. The stimulus changes every input at the falling edge and holds it across the next rising edge. It keeps the accumulator far from wrap-around by using at most a few hundred pulses per run. It moves `prediv_sel_i` only while capture is off, so no divider phase straddles a code change.

// File: rtl/enc_vel_pkg.sv
package enc_vel_pkg;

    localparam int unsigned SEL_W_DEF   = 3;
    localparam int unsigned TIMER_W_DEF = 32;
    localparam int unsigned COUNT_W_DEF = 32;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

    typedef struct packed {
        logic run;
        logic hold;
    } vel_ctrl_t;

    function automatic vel_ctrl_t make_ctrl(input logic enc_en, input logic vel_en,
                                            input logic stall_en, input logic halt);
        vel_ctrl_t c;
        c.run  = enc_en & vel_en;
        c.hold = stall_en & halt;
        return c;
    endfunction

endpackage

// File: rtl/enc_vel_prediv.sv
module enc_vel_prediv
    import enc_vel_pkg::*;
#(
    parameter int unsigned SEL_W = SEL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  vel_ctrl_t        ctrl_i,
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned PH_W = (1 << SEL_W) - 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] mask;
    logic            accept;

    assign mask   = PH_W'((32'd1 << sel_i) - 32'd1);
    assign accept = ctrl_i.run & ~ctrl_i.hold & pulse_i;
    assign tick_o = accept & (phase_q >= mask);

    always_ff @(posedge clk) begin
        if (rst || !ctrl_i.run) begin
            phase_q <= '0;
        end else if (accept) begin
            if (phase_q >= mask) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
        end
    end

    p_phase_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.run |=> phase_q == '0);
    p_tick_needs_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (pulse_i && ctrl_i.run));
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && ctrl_i.hold) |=> $stable(phase_q));

endmodule

// File: rtl/enc_vel_timer.sv
module enc_vel_timer
    import enc_vel_pkg::*;
#(
    parameter int unsigned TIMER_W = TIMER_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  vel_ctrl_t          ctrl_i,
    input  logic [TIMER_W-1:0] load_i,
    output logic [TIMER_W-1:0] timer_o,
    output logic               expire_o,
    output logic               win_end_o
);
    logic [TIMER_W-1:0] timer_q;
    logic               win_end_q;

    assign expire_o  = ctrl_i.run & ~ctrl_i.hold & (timer_q == '0);
    assign timer_o   = timer_q;
    assign win_end_o = win_end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q   <= '0;
            win_end_q <= 1'b0;
        end else begin
            win_end_q <= expire_o;
            if (!ctrl_i.run)       timer_q <= load_i;
            else if (ctrl_i.hold)  timer_q <= timer_q;
            else if (expire_o)     timer_q <= load_i;
            else                   timer_q <= timer_q - 1'b1;
        end
    end

    p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && !ctrl_i.hold && timer_q != '0) |=> timer_q == $past(timer_q) - 1'b1);
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && !ctrl_i.hold && timer_q == '0) |=> timer_q == $past(load_i));
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && ctrl_i.hold) |=> ($stable(timer_q) && !win_end_q));
    p_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && !ctrl_i.hold && timer_q == '0) |=> win_end_q);
    p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.run |=> (!win_end_q && timer_q == $past(load_i)));

endmodule

// File: rtl/enc_vel_accum.sv
module enc_vel_accum
    import enc_vel_pkg::*;
#(
    parameter int unsigned COUNT_W = COUNT_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  vel_ctrl_t                 ctrl_i,
    input  logic                      tick_i,
    input  dir_e                      dir_i,
    input  logic                      expire_i,
    output logic signed [COUNT_W-1:0] accum_o,
    output logic signed [COUNT_W-1:0] speed_o
);
    logic signed [COUNT_W-1:0] accum_q;
    logic signed [COUNT_W-1:0] speed_q;
    logic signed [COUNT_W-1:0] step;

    always_comb begin
        if (!tick_i)              step = '0;
        else if (dir_i == DIR_REV) step = '1;
        else                      step = COUNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            accum_q <= '0;
            speed_q <= '0;
        end else if (!ctrl_i.run) begin
            accum_q <= '0;
        end else if (!ctrl_i.hold) begin
            if (expire_i) begin
                speed_q <= accum_q;
                accum_q <= step;
            end else begin
                accum_q <= accum_q + step;
            end
        end
    end

    assign accum_o = accum_q;
    assign speed_o = speed_q;

    p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.run |=> (accum_q == '0 && $stable(speed_q)));
    p_latch_r6: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> speed_q == $past(accum_q));
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (expire_i && !tick_i) |=> accum_q == '0);
    p_fwd_step_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && !ctrl_i.hold && !expire_i && tick_i && dir_i == DIR_FWD)
        |=> accum_q == $past(accum_q) + 1);
    p_rev_step_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && !ctrl_i.hold && !expire_i && tick_i && dir_i == DIR_REV)
        |=> accum_q == $past(accum_q) - 1);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.run && ctrl_i.hold) |=> ($stable(accum_q) && $stable(speed_q)));

endmodule

// File: rtl/enc_vel_capture.sv
module enc_vel_capture
    import enc_vel_pkg::*;
#(
    parameter int unsigned SEL_W   = SEL_W_DEF,
    parameter int unsigned TIMER_W = TIMER_W_DEF,
    parameter int unsigned COUNT_W = COUNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enc_en_i,
    input  logic               vel_en_i,
    input  logic               stall_en_i,
    input  logic               halt_i,
    input  logic               pulse_i,
    input  logic               dir_i,
    input  logic [SEL_W-1:0]   prediv_sel_i,
    input  logic [TIMER_W-1:0] load_val_i,
    output logic [TIMER_W-1:0] timer_o,
    output logic [COUNT_W-1:0] accum_o,
    output logic [COUNT_W-1:0] speed_o,
    output logic               win_end_o
);
    vel_ctrl_t                 ctrl;
    logic                      tick;
    logic                      expire;
    logic signed [COUNT_W-1:0] accum_s;
    logic signed [COUNT_W-1:0] speed_s;
    dir_e                      dir;

    assign ctrl = make_ctrl(enc_en_i, vel_en_i, stall_en_i, halt_i);
    assign dir  = dir_e'(dir_i);

    enc_vel_prediv #(.SEL_W(SEL_W)) u_prediv (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl),
        .pulse_i(pulse_i),
        .sel_i  (prediv_sel_i),
        .tick_o (tick)
    );

    enc_vel_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl),
        .load_i   (load_val_i),
        .timer_o  (timer_o),
        .expire_o (expire),
        .win_end_o(win_end_o)
    );

    enc_vel_accum #(.COUNT_W(COUNT_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl),
        .tick_i  (tick),
        .dir_i   (dir),
        .expire_i(expire),
        .accum_o (accum_s),
        .speed_o (speed_s)
    );

    assign accum_o = accum_s;
    assign speed_o = speed_s;

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !enc_en_i |=> (accum_o == '0 && !win_end_o));
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (timer_o == '0 && accum_o == '0 && speed_o == '0 && !win_end_o));

endmodule

// File: tb/enc_vel_capture_tb_top.sv
module enc_vel_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_en = 1'b0, vel_en = 1'b0, stall_en = 1'b0, halt = 1'b0;
    logic        pulse = 1'b0, dir = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [31:0] load = 32'd9;
    logic [31:0] timer, accum, speed;
    logic        win_end;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    enc_vel_capture dut_i (
        .clk(clk), .rst(rst), .enc_en_i(enc_en), .vel_en_i(vel_en),
        .stall_en_i(stall_en), .halt_i(halt), .pulse_i(pulse), .dir_i(dir),
        .prediv_sel_i(sel), .load_val_i(load), .timer_o(timer),
        .accum_o(accum), .speed_o(speed), .win_end_o(win_end)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [2:0] k, input logic [31:0] ld);
        vel_en = 1'b0; pulse = 1'b0; sel = k; load = ld;
        cyc(1);
        enc_en = 1'b1; vel_en = 1'b1;
    endtask

    task automatic t_reset();
        cyc(2);
        check("R1 timer", timer, 0);
        check("R1 accum", accum, 0);
        check("R1 speed", speed, 0);
        check("R1 strobe", {31'd0, win_end}, 0);
        rst = 1'b0;
        cyc(1);
        check("R2 idle timer load", timer, 9);
    endtask

    task automatic t_timer();
        restart(3'd0, 32'd9);
        cyc(1);
        check("R5 first step", timer, 8);
        cyc(8);
        check("R5 reaches zero", timer, 0);
        check("R7 no strobe early", {31'd0, win_end}, 0);
        cyc(1);
        check("R5 reload", timer, 9);
        check("R7 strobe", {31'd0, win_end}, 1);
        cyc(1);
        check("R7 single cycle", {31'd0, win_end}, 0);
        check("R5 after reload", timer, 8);
    endtask

    task automatic t_prediv(input logic [2:0] k, input int n, input int exp);
        restart(k, 32'd2000);
        dir = 1'b0;
        for (int i = 0; i < n; i++) begin
            pulse = 1'b1; cyc(1);
            pulse = 1'b0; cyc(1);
        end
        check($sformatf("R3 divide code %0d", k), accum, exp);
    endtask

    task automatic t_prediv_clear();
        restart(3'd2, 32'd2000);
        pulse = 1'b1; cyc(3); pulse = 1'b0;
        check("R3 below divisor", accum, 0);
        vel_en = 1'b0; cyc(1); vel_en = 1'b1;
        pulse = 1'b1; cyc(1); pulse = 1'b0; cyc(1);
        check("R3 phase cleared", accum, 0);
        pulse = 1'b1; cyc(3); pulse = 1'b0; cyc(1);
        check("R3 full group after clear", accum, 1);
    endtask

    task automatic t_dir();
        restart(3'd0, 32'd2000);
        dir = 1'b1; pulse = 1'b1; cyc(5); pulse = 1'b0; cyc(1);
        check("R4 reverse", accum, -32'sd5);
        dir = 1'b0; pulse = 1'b1; cyc(2); pulse = 1'b0; cyc(1);
        check("R4 forward", accum, -32'sd3);
    endtask

    task automatic t_latch();
        restart(3'd0, 32'd9);
        dir = 1'b0;
        pulse = 1'b1; cyc(4);
        pulse = 1'b0; cyc(5);
        pulse = 1'b1; cyc(1);
        pulse = 1'b0;
        check("R6 speed latched", speed, 4);
        check("R6 boundary pulse in new window", accum, 1);
        check("R7 strobe with result", {31'd0, win_end}, 1);
        cyc(1);
        check("R7 strobe drops", {31'd0, win_end}, 0);
        check("R6 speed held in window", speed, 4);
        cyc(9);
        check("R6 second window", speed, 1);
        check("R6 accum restarted", accum, 0);
    endtask

    task automatic t_idle_keep();
        logic [31:0] s;
        s = speed;
        vel_en = 1'b0; load = 32'd77; pulse = 1'b1; cyc(3); pulse = 1'b0;
        check("R2 speed kept", speed, s);
        check("R2 accum clear", accum, 0);
        check("R2 timer loads", timer, 77);
        check("R2 no strobe", {31'd0, win_end}, 0);
    endtask

    task automatic t_stall();
        logic [31:0] t0, a0;
        restart(3'd0, 32'd1000);
        pulse = 1'b1; cyc(3);
        t0 = timer; a0 = accum;
        stall_en = 1'b1; halt = 1'b1; cyc(5);
        check("R8 timer frozen", timer, t0);
        check("R8 accum frozen", accum, a0);
        stall_en = 1'b0; cyc(3);
        check("R8 halt alone timer", timer, t0 - 3);
        check("R8 halt alone accum", accum, a0 + 3);
        halt = 1'b0; pulse = 1'b0; cyc(1);
    endtask

    task automatic t_gate();
        restart(3'd0, 32'd5);
        enc_en = 1'b0; pulse = 1'b1; cyc(12); pulse = 1'b0;
        check("R9 accum gated", accum, 0);
        check("R9 timer held at load", timer, 5);
        check("R9 no strobe", {31'd0, win_end}, 0);
    endtask

    initial begin
        t_reset();
        t_timer();
        t_prediv(3'd0, 300, 300);
        t_prediv(3'd1, 300, 150);
        t_prediv(3'd3, 300, 37);
        t_prediv(3'd7, 300, 2);
        t_prediv_clear();
        t_dir();
        t_latch();
        t_idle_keep();
        t_stall();
        t_gate();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule